// File: doc/BRIEF.md
# Bit-Addressable Data RAM with Register-Bank View

This block is a 2 KB on-chip data RAM that a processor core reaches through two request ports sharing one storage array. The memory port carries ordinary byte and 16-bit word reads and writes, plus single-bit set, clear, toggle and test. Those bit operations are honoured only in the top 256 bytes of the RAM and rejected anywhere else. The register port sees the same array as a bank of sixteen word registers, or sixteen byte registers, placed at a programmable base pointer. On this port bit operations reach any location.

Both ports may issue one request per clock. Results come back registered one cycle later, with an acknowledge. Within a cycle the memory-port operation takes effect first and the register-port operation second. A register access therefore observes, and builds on, a memory-port write to the same word in the same cycle. The stack and the user variables share the array with the register bank, so either port can read data that the other port wrote.

Top module: `bitram_core`

## Requirements
- R1: A word access (size 0) at an even byte address A reads or writes the word made of byte A in bits 7:0 and byte A+1 in bits 15:8. The result appears on the read data output in the cycle after the request.
- R2: A byte write (size 1) changes only the addressed byte and leaves the other byte of its word unchanged. A byte read returns the byte in bits 7:0 with bits 15:8 zero.
- R3: A memory-port word read or write at an odd address raises the error output in the cycle after the request. The storage is not changed and the read data is zero.
- R4: Memory-port bit operations use op codes 2 set, 3 clear, 4 toggle and 5 test. They address bit m_bit of the byte at m_addr, which is word bit {m_addr[0], m_bit}. Set, clear and toggle atomically rewrite that word. Test returns the bit in read data bit 0 with all other bits zero and changes nothing. Op 0 is read, op 1 is write, and ops 6 and 7 act as read.
- R5: A memory-port bit operation at an address below 0x700 raises the error output, leaves the storage unchanged and returns zero data.
- R6: Writing the base pointer stores bits 10:1 of the written value with bit 0 forced to zero, from the next cycle on. In word mode (r_size 0), register n maps to byte address (base + 2n) mod 2048. The base is zero after reset.
- R7: In byte mode (r_size 1), register number k maps to byte address (base + k) mod 2048. Even k is the low byte of word register k/2 and odd k is its high byte.
- R8: Register-port bit operations use the same op codes as R4 and are accepted at every address. In word mode r_bit selects word bit 0 to 15. In byte mode r_bit[2:0] selects a bit of the addressed byte.
- R9: Both ports access one storage array, so data written through either port is read back through the other.
- R10: When both ports address the same word in one cycle, the memory-port operation is applied first and the register-port operation is applied to its result. A register read in that cycle returns the newly written value.
- R11: Each request is acknowledged in the following cycle. The acknowledge, error and read data outputs are registered and are zero after reset and while nothing is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Memory-port request |
| m_op | input | 3 | Memory-port operation code |
| m_size | input | 1 | 1 = byte, 0 = word |
| m_addr | input | 11 | Byte address |
| m_bit | input | 3 | Bit within the addressed byte for bit operations |
| m_wdata | input | 16 | Write data (bits 7:0 for byte writes) |
| m_ack | output | 1 | Memory-port result valid |
| m_err | output | 1 | Alignment or bit-window error |
| m_rdata | output | 16 | Memory-port read data |
| bp_we | input | 1 | Base pointer write enable |
| bp_wdata | input | 11 | New base pointer value |
| r_req | input | 1 | Register-port request |
| r_op | input | 3 | Register-port operation code |
| r_size | input | 1 | 1 = byte register, 0 = word register |
| r_num | input | 4 | Register number |
| r_bit | input | 4 | Bit number for register bit operations |
| r_wdata | input | 16 | Register write data |
| r_ack | output | 1 | Register-port result valid |
| r_rdata | output | 16 | Register-port read data |

## Verification
The assertions check on every cycle that each request is acknowledged one cycle later and that errors arise only with an acknowledge and with zero data. They also check that misaligned word accesses and bit operations outside the window are flagged, and that bit tests and byte reads return nothing above their field. The stored values themselves can only be shown by the bench scenarios. These cover lane merging, bit read-modify-write, base-pointer relocation and wrap, byte-register mapping, sharing of data between the ports, and the ordering when both ports hit the same word in one cycle. A bench-side model of the array predicts each of these results.

// File: rtl/bitram_pkg.sv
`timescale 1ns/1ps
package bitram_pkg;

    localparam int DW = 16;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_SET   = 3'd2,
        OP_CLR   = 3'd3,
        OP_TGL   = 3'd4,
        OP_TEST  = 3'd5
    } op_e;

    typedef struct packed {
        logic          wr;
        logic [DW-1:0] nword;
        logic [DW-1:0] rdata;
    } alu_res_t;

    function automatic logic is_bit_op(input logic [2:0] op);
        return (op >= 3'd2) && (op <= 3'd5);
    endfunction

    // Applies one operation to a word; byte mode picks the lane with hi.
    function automatic alu_res_t apply_op(
        input logic [2:0]    op,
        input logic [DW-1:0] old,
        input logic          bmode,
        input logic          hi,
        input logic [DW-1:0] wd,
        input logic [3:0]    bpos
    );
        alu_res_t r;
        r.wr    = 1'b0;
        r.nword = old;
        r.rdata = '0;
        case (op)
            OP_WRITE: begin
                r.wr = 1'b1;
                if (!bmode)  r.nword = wd;
                else if (hi) r.nword = {wd[7:0], old[7:0]};
                else         r.nword = {old[15:8], wd[7:0]};
            end
            OP_SET: begin
                r.wr = 1'b1;
                r.nword[bpos] = 1'b1;
            end
            OP_CLR: begin
                r.wr = 1'b1;
                r.nword[bpos] = 1'b0;
            end
            OP_TGL: begin
                r.wr = 1'b1;
                r.nword[bpos] = ~old[bpos];
            end
            OP_TEST: r.rdata[0] = old[bpos];
            default: begin
                if (!bmode)  r.rdata = old;
                else if (hi) r.rdata = {8'h00, old[15:8]};
                else         r.rdata = {8'h00, old[7:0]};
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bitram_memdec.sv
`timescale 1ns/1ps
module bitram_memdec
    import bitram_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int WIN_BYTES = 256,
    localparam int IDX_W    = ADDR_W - 1
) (
    input  logic              req,
    input  logic [2:0]        op,
    input  logic              size_b,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bsel,
    output logic [IDX_W-1:0]  idx,
    output logic              hi,
    output logic [3:0]        bpos,
    output logic              err,
    output logic              go
);
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'((1 << ADDR_W) - WIN_BYTES);

    logic bit_req;
    logic in_win;
    logic misalign;

    always_comb begin
        bit_req  = is_bit_op(op);
        in_win   = {1'b0, addr} >= WIN_LO;
        misalign = !bit_req && !size_b && addr[0];
        idx      = addr[ADDR_W-1:1];
        hi       = addr[0];
        bpos     = {addr[0], bsel};
        err      = req && ((bit_req && !in_win) || misalign);
        go       = req && !err;
    end
endmodule

// File: rtl/bitram_regmap.sv
`timescale 1ns/1ps
module bitram_regmap #(
    parameter int ADDR_W  = 11,
    parameter int NREG    = 16,
    localparam int NUM_W  = $clog2(NREG),
    localparam int IDX_W  = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bp_we,
    input  logic [ADDR_W-1:0] bp_wdata,
    input  logic              size_b,
    input  logic [NUM_W-1:0]  num,
    input  logic [3:0]        rbit,
    output logic [IDX_W-1:0]  idx,
    output logic              hi,
    output logic [3:0]        bpos
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] baddr;

    always_ff @(posedge clk) begin
        if (rst)        base_q <= '0;
        else if (bp_we) base_q <= {bp_wdata[ADDR_W-1:1], 1'b0};
    end

    always_comb begin
        offs  = size_b ? ADDR_W'(num) : ADDR_W'({num, 1'b0});
        baddr = base_q + offs;
        idx   = baddr[ADDR_W-1:1];
        hi    = baddr[0];
        bpos  = size_b ? {baddr[0], rbit[2:0]} : rbit;
    end
endmodule

// File: rtl/bitram_store.sv
`timescale 1ns/1ps
module bitram_store
    import bitram_pkg::*;
#(
    parameter int IDX_W  = 10,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             m_go,
    input  logic [2:0]       m_op,
    input  logic [IDX_W-1:0] m_idx,
    input  logic             m_bmode,
    input  logic             m_hi,
    input  logic [DW-1:0]    m_wd,
    input  logic [3:0]       m_bpos,
    input  logic             r_go,
    input  logic [2:0]       r_op,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_bmode,
    input  logic             r_hi,
    input  logic [DW-1:0]    r_wd,
    input  logic [3:0]       r_bpos,
    output logic [DW-1:0]    m_rd,
    output logic [DW-1:0]    r_rd
);
    logic [DW-1:0] mem [WORDS];

    alu_res_t      m_res;
    alu_res_t      r_res;
    logic [DW-1:0] r_old;
    logic          m_wr;
    logic          r_wr;

    always_comb begin
        m_res = apply_op(m_op, mem[m_idx], m_bmode, m_hi, m_wd, m_bpos);
        m_wr  = m_go && m_res.wr;
        // register port sees the memory port's same-cycle write
        r_old = (m_wr && (m_idx == r_idx)) ? m_res.nword : mem[r_idx];
        r_res = apply_op(r_op, r_old, r_bmode, r_hi, r_wd, r_bpos);
        r_wr  = r_go && r_res.wr;
        m_rd  = m_res.rdata;
        r_rd  = r_res.rdata;
    end

    always_ff @(posedge clk) begin
        if (m_wr) mem[m_idx] <= m_res.nword;
        if (r_wr) mem[r_idx] <= r_res.nword;
    end
endmodule

// File: rtl/bitram_core.sv
`timescale 1ns/1ps
module bitram_core
    import bitram_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int WIN_BYTES = 256,
    parameter int NREG      = 16,
    localparam int IDX_W    = ADDR_W - 1,
    localparam int NUM_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_req,
    input  logic [2:0]        m_op,
    input  logic              m_size,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [2:0]        m_bit,
    input  logic [DW-1:0]     m_wdata,
    output logic              m_ack,
    output logic              m_err,
    output logic [DW-1:0]     m_rdata,
    input  logic              bp_we,
    input  logic [ADDR_W-1:0] bp_wdata,
    input  logic              r_req,
    input  logic [2:0]        r_op,
    input  logic              r_size,
    input  logic [NUM_W-1:0]  r_num,
    input  logic [3:0]        r_bit,
    input  logic [DW-1:0]     r_wdata,
    output logic              r_ack,
    output logic [DW-1:0]     r_rdata
);
    logic [IDX_W-1:0] m_idx;
    logic             m_hi;
    logic [3:0]       m_bpos;
    logic             m_dec_err;
    logic             m_go;
    logic [IDX_W-1:0] r_idx;
    logic             r_hi;
    logic [3:0]       r_bpos;
    logic [DW-1:0]    m_rd;
    logic [DW-1:0]    r_rd;

    bitram_memdec #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_memdec (
        .req(m_req), .op(m_op), .size_b(m_size), .addr(m_addr), .bsel(m_bit),
        .idx(m_idx), .hi(m_hi), .bpos(m_bpos), .err(m_dec_err), .go(m_go)
    );

    bitram_regmap #(.ADDR_W(ADDR_W), .NREG(NREG)) u_regmap (
        .clk(clk), .rst(rst), .bp_we(bp_we), .bp_wdata(bp_wdata),
        .size_b(r_size), .num(r_num), .rbit(r_bit),
        .idx(r_idx), .hi(r_hi), .bpos(r_bpos)
    );

    bitram_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk),
        .m_go(m_go), .m_op(m_op), .m_idx(m_idx), .m_bmode(m_size), .m_hi(m_hi),
        .m_wd(m_wdata), .m_bpos(m_bpos),
        .r_go(r_req), .r_op(r_op), .r_idx(r_idx), .r_bmode(r_size), .r_hi(r_hi),
        .r_wd(r_wdata), .r_bpos(r_bpos),
        .m_rd(m_rd), .r_rd(r_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            m_ack   <= 1'b0;
            m_err   <= 1'b0;
            m_rdata <= '0;
            r_ack   <= 1'b0;
            r_rdata <= '0;
        end else begin
            m_ack   <= m_req;
            m_err   <= m_dec_err;
            m_rdata <= m_go ? m_rd : '0;
            r_ack   <= r_req;
            r_rdata <= r_req ? r_rd : '0;
        end
    end
endmodule

// File: rtl/bitram_chk.sv
`timescale 1ns/1ps
module bitram_chk #(
    parameter int ADDR_W    = 11,
    parameter int WIN_BYTES = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              m_req,
    input logic [2:0]        m_op,
    input logic              m_size,
    input logic [ADDR_W-1:0] m_addr,
    input logic              m_ack,
    input logic              m_err,
    input logic [15:0]       m_rdata,
    input logic              r_req,
    input logic [2:0]        r_op,
    input logic              r_ack,
    input logic [15:0]       r_rdata
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'((1 << ADDR_W) - WIN_BYTES);

    logic m_bitop;
    logic m_plain;
    assign m_bitop = (m_op >= 3'd2) && (m_op <= 3'd5);
    assign m_plain = !m_bitop;

    AST_MEM_ACK: assert property (@(posedge clk) disable iff (rst)
        m_req |=> m_ack);                                          // R11
    AST_REG_ACK: assert property (@(posedge clk) disable iff (rst)
        r_req |=> r_ack);                                          // R11
    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        m_err |-> (m_ack && m_rdata == 16'h0));                    // R3
    AST_ODD_WORD: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_plain && !m_size && m_addr[0]) |=> m_err);     // R3
    AST_BIT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_bitop && ({1'b0, m_addr} < LO)) |=> m_err);    // R5
    AST_MEM_TEST_BIT: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_op == 3'd5) |=> (m_rdata[15:1] == 15'h0));     // R4
    AST_REG_TEST_BIT: assert property (@(posedge clk) disable iff (rst)
        (r_req && r_op == 3'd5) |=> (r_rdata[15:1] == 15'h0));     // R8
    AST_BYTE_READ: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_plain && m_op != 3'd1 && m_size) |=> (m_rdata[15:8] == 8'h0)); // R2
endmodule

bind bitram_core bitram_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (
    .clk(clk), .rst(rst), .m_req(m_req), .m_op(m_op), .m_size(m_size),
    .m_addr(m_addr), .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
    .r_req(r_req), .r_op(r_op), .r_ack(r_ack), .r_rdata(r_rdata)
);

// File: tb/test_bitram_core.sv
`timescale 1ns/1ps
module test_bitram_core;
    logic        clk = 1'b0;
    logic        rst;
    logic        m_req, m_size, bp_we, r_req, r_size;
    logic [2:0]  m_op, m_bit, r_op;
    logic [10:0] m_addr, bp_wdata;
    logic [15:0] m_wdata, r_wdata;
    logic [3:0]  r_num, r_bit;
    logic        m_ack, m_err, r_ack;
    logic [15:0] m_rdata, r_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [15:0] model [1024];
    logic [10:0] base_m;

    always #2 clk = ~clk;

    bitram_core i_bitram_core (
        .clk(clk), .rst(rst),
        .m_req(m_req), .m_op(m_op), .m_size(m_size), .m_addr(m_addr), .m_bit(m_bit),
        .m_wdata(m_wdata), .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
        .bp_we(bp_we), .bp_wdata(bp_wdata),
        .r_req(r_req), .r_op(r_op), .r_size(r_size), .r_num(r_num), .r_bit(r_bit),
        .r_wdata(r_wdata), .r_ack(r_ack), .r_rdata(r_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Applies an operation to the model word at byte address a; returns read data.
    function automatic logic [15:0] model_op(input logic [2:0] op, input logic [10:0] a,
                                             input logic bmode, input logic [3:0] b,
                                             input logic [15:0] wd);
        logic [15:0] w;
        logic [15:0] rd;
        w  = model[a[10:1]];
        rd = 16'h0;
        case (op)
            3'd1: begin
                if (!bmode)    w = wd;
                else if (a[0]) w[15:8] = wd[7:0];
                else           w[7:0] = wd[7:0];
            end
            3'd2: w[b] = 1'b1;
            3'd3: w[b] = 1'b0;
            3'd4: w[b] = ~w[b];
            3'd5: rd = {15'h0, w[b]};
            default: rd = !bmode ? w : (a[0] ? {8'h0, w[15:8]} : {8'h0, w[7:0]});
        endcase
        model[a[10:1]] = w;
        return rd;
    endfunction

    // Drives one cycle of stimulus, predicts, waits, compares.
    task automatic cycle(input string tag,
                         input logic mq, input logic [2:0] mo, input logic ms,
                         input logic [10:0] ma, input logic [2:0] mb, input logic [15:0] mw,
                         input logic rq, input logic [2:0] ro, input logic rs,
                         input logic [3:0] rn, input logic [3:0] rb, input logic [15:0] rw,
                         input logic bw, input logic [10:0] bv);
        logic isbit, err, rbit_op;
        logic [15:0] em, er;
        logic [10:0] ra;
        logic [3:0]  rbp;
        string tm, tr;
        m_req = mq; m_op = mo; m_size = ms; m_addr = ma; m_bit = mb; m_wdata = mw;
        r_req = rq; r_op = ro; r_size = rs; r_num = rn; r_bit = rb; r_wdata = rw;
        bp_we = bw; bp_wdata = bv;
        isbit = (mo >= 3'd2) && (mo <= 3'd5);
        err   = mq && ((isbit && ma < 11'h700) || (!isbit && !ms && ma[0]));
        em    = 16'h0;
        if (mq && !err) em = model_op(mo, ma, ms, {ma[0], mb}, mw);
        er = 16'h0;
        ra = base_m + (rs ? {7'h0, rn} : {6'h0, rn, 1'b0});
        rbp = rs ? {ra[0], rb[2:0]} : rb;
        if (rq) er = model_op(ro, ra, rs, rbp, rw);
        if (bw) base_m = {bv[10:1], 1'b0};
        rbit_op = (ro >= 3'd2) && (ro <= 3'd5);
        if (tag != "") begin tm = tag; tr = tag; end
        else begin
            tm = err ? (isbit ? "R5" : "R3") : (isbit ? "R4" : (ms ? "R2" : "R1"));
            tr = rbit_op ? "R8" : (rs ? "R7" : "R6");
        end
        @(negedge clk);
        chk({tm, " m_ack R11"}, {15'h0, m_ack}, {15'h0, mq});
        chk({tm, " m_err"}, {15'h0, m_err}, {15'h0, err});
        chk({tm, " m_rdata"}, m_rdata, em);
        chk({tr, " r_ack R11"}, {15'h0, r_ack}, {15'h0, rq});
        chk({tr, " r_rdata"}, r_rdata, er);
    endtask

    task automatic mem_only(input string tag, input logic [2:0] op, input logic sz,
                            input logic [10:0] a, input logic [2:0] b, input logic [15:0] d);
        cycle(tag, 1'b1, op, sz, a, b, d, 1'b0, 3'd0, 1'b0, 4'd0, 4'd0, 16'h0, 1'b0, 11'h0);
    endtask

    task automatic reg_only(input string tag, input logic [2:0] op, input logic sz,
                            input logic [3:0] n, input logic [3:0] b, input logic [15:0] d);
        cycle(tag, 1'b0, 3'd0, 1'b0, 11'h0, 3'd0, 16'h0, 1'b1, op, sz, n, b, d, 1'b0, 11'h0);
    endtask

    task automatic set_base(input logic [10:0] v);
        cycle("R6", 1'b0, 3'd0, 1'b0, 11'h0, 3'd0, 16'h0, 1'b0, 3'd0, 1'b0, 4'd0, 4'd0, 16'h0, 1'b1, v);
    endtask

    initial begin
        void'($urandom(32'd4242));
        base_m = 11'h0;
        rst = 1'b1;
        m_req = 0; m_op = 0; m_size = 0; m_addr = 0; m_bit = 0; m_wdata = 0;
        r_req = 0; r_op = 0; r_size = 0; r_num = 0; r_bit = 0; r_wdata = 0;
        bp_we = 0; bp_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state of registered outputs
        chk("R11 reset m_ack", {15'h0, m_ack}, 16'h0);
        chk("R11 reset m_err", {15'h0, m_err}, 16'h0);
        chk("R11 reset m_rdata", m_rdata, 16'h0);
        chk("R11 reset r_rdata", r_rdata, 16'h0);

        // Fill the whole array through word writes (R9 shared storage setup)
        for (int i = 0; i < 1024; i++)
            mem_only("R1", 3'd1, 1'b0, 11'(i * 2), 3'd0, 16'($urandom));

        // R6: base pointer reset value is zero, R0 at byte 0
        reg_only("R6", 3'd0, 1'b0, 4'd0, 4'd0, 16'h0);
        chk("R6 R0 at base 0", r_rdata, model[0]);

        // R1: little-endian word
        mem_only("R1", 3'd1, 1'b0, 11'h010, 3'd0, 16'h1234);
        mem_only("R1", 3'd0, 1'b1, 11'h010, 3'd0, 16'h0);
        chk("R1 low byte", m_rdata, 16'h0034);
        mem_only("R1", 3'd0, 1'b1, 11'h011, 3'd0, 16'h0);
        chk("R1 high byte", m_rdata, 16'h0012);

        // R2: byte lane merge
        mem_only("R2", 3'd1, 1'b1, 11'h011, 3'd0, 16'hFFAB);
        mem_only("R2", 3'd0, 1'b0, 11'h010, 3'd0, 16'h0);
        chk("R2 merged word", m_rdata, 16'hAB34);

        // R3: misaligned word write suppressed
        mem_only("R3", 3'd1, 1'b0, 11'h011, 3'd0, 16'hFFFF);
        chk("R3 err", {15'h0, m_err}, 16'h1);
        mem_only("R3", 3'd0, 1'b0, 11'h010, 3'd0, 16'h0);
        chk("R3 unchanged", m_rdata, 16'hAB34);

        // R4: bit ops in window
        mem_only("R4", 3'd1, 1'b0, 11'h7F0, 3'd0, 16'h0000);
        mem_only("R4", 3'd2, 1'b0, 11'h7F1, 3'd3, 16'h0);
        mem_only("R4", 3'd0, 1'b0, 11'h7F0, 3'd0, 16'h0);
        chk("R4 set bit 11", m_rdata, 16'h0800);
        mem_only("R4", 3'd5, 1'b0, 11'h7F1, 3'd3, 16'h0);
        chk("R4 test", m_rdata, 16'h0001);
        mem_only("R4", 3'd4, 1'b0, 11'h7F0, 3'd0, 16'h0);
        mem_only("R4", 3'd3, 1'b0, 11'h7F1, 3'd3, 16'h0);
        mem_only("R4", 3'd0, 1'b0, 11'h7F0, 3'd0, 16'h0);
        chk("R4 toggle/clear", m_rdata, 16'h0001);

        // R5: bit op just below window rejected
        mem_only("R5", 3'd1, 1'b0, 11'h6FE, 3'd0, 16'h0000);
        mem_only("R5", 3'd2, 1'b0, 11'h6FF, 3'd7, 16'h0);
        chk("R5 err", {15'h0, m_err}, 16'h1);
        mem_only("R5", 3'd0, 1'b0, 11'h6FE, 3'd0, 16'h0);
        chk("R5 unchanged", m_rdata, 16'h0000);

        // R6: odd base rounds down, wrap at top
        set_base(11'h7FF);
        mem_only("R6", 3'd1, 1'b0, 11'h000, 3'd0, 16'hC0DE);
        reg_only("R6", 3'd0, 1'b0, 4'd1, 4'd0, 16'h0);
        chk("R6 wrap R1", r_rdata, 16'hC0DE);

        // R7: byte register k=3 (high byte of R1) at base 0x100
        set_base(11'h100);
        reg_only("R7", 3'd1, 1'b1, 4'd3, 4'd0, 16'h005A);
        mem_only("R7", 3'd0, 1'b1, 11'h103, 3'd0, 16'h0);
        chk("R7 RH1 location", m_rdata, 16'h005A);

        // R8: register bit op outside memory-port window
        reg_only("R8", 3'd1, 1'b0, 4'd2, 4'd0, 16'h0000);
        reg_only("R8", 3'd2, 1'b0, 4'd2, 4'd15, 16'h0);
        reg_only("R8", 3'd5, 1'b0, 4'd2, 4'd15, 16'h0);
        chk("R8 test bit 15", r_rdata, 16'h0001);

        // R9: write via registers, read via memory
        reg_only("R9", 3'd1, 1'b0, 4'd5, 4'd0, 16'hBEEF);
        mem_only("R9", 3'd0, 1'b0, 11'h10A, 3'd0, 16'h0);
        chk("R9 shared", m_rdata, 16'hBEEF);

        // R10: same-cycle memory write then register read and merge
        cycle("R10", 1'b1, 3'd1, 1'b0, 11'h104, 3'd0, 16'h7777,
              1'b1, 3'd0, 1'b0, 4'd2, 4'd0, 16'h0, 1'b0, 11'h0);
        chk("R10 forwarded read", r_rdata, 16'h7777);
        cycle("R10", 1'b1, 3'd1, 1'b0, 11'h104, 3'd0, 16'h1111,
              1'b1, 3'd1, 1'b1, 4'd5, 4'd0, 16'h0099, 1'b0, 11'h0);
        mem_only("R10", 3'd0, 1'b0, 11'h104, 3'd0, 16'h0);
        chk("R10 ordered merge", m_rdata, 16'h9911);

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [10:0] ma;
            logic [2:0]  mo;
            mo = 3'($urandom);
            ma = ($urandom % 2) ? 11'(11'h700 + ($urandom % 256)) : 11'($urandom);
            cycle("", ($urandom % 4) != 0, mo, 1'($urandom), ma, 3'($urandom), 16'($urandom),
                  ($urandom % 3) != 0, 3'($urandom), 1'($urandom), 4'($urandom), 4'($urandom),
                  16'($urandom), ($urandom % 16) == 0, 11'($urandom));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule